// File: doc/BRIEF.md
# Outer-Block Program Bank Selector

This block maps the CPU program window $8000-$FFFF onto a 512 KB program ROM that is split into two 256 KB halves. The CPU writes registers through a write port. Address bit 15 qualifies the write, and address bits 3:0 select one of sixteen register slots. Slots 0 to 7 hold eight byte-wide outer-select registers. Only bit 0 of slot 0 steers the ROM: it picks which 256 KB half both program windows use. Slot 8 holds the inner 16 KB bank number.

The lower window ($8000-$BFFF) shows the inner bank inside the selected half. The upper window ($C000-$FFFF) is pinned to the last 16 KB of that same half. It is not pinned to the last bank of the whole ROM. Writes to slots 9 to 12 are handed on to neighbouring mirroring and interrupt logic. The $6000-$7FFF range is flagged for work RAM and is otherwise left alone.

Top module: `outer_bank_sel`

## Requirements
- R1: A write with cpu_addr_i[15]=0 (for example into $6000-$7FFF) changes no register, so the program mapping stays as it was.
- R2: A write to slot index cpu_addr_i[3:0] in 0..7 loads that outer-select register. Slots 1..7 and bits 7:1 of slot 0 have no effect on prg_addr_o.
- R3: Bit 0 of outer-select slot 0 becomes bit 4 of the 16 KB bank number for both windows. It takes effect in the cycle after the write edge.
- R4: A write to slot 8 loads data bits 3:0 as the inner bank, and data bits 7:4 are ignored.
- R5: For cpu_addr_i in $8000-$BFFF (bit 14 = 0), the bank is {outer, inner[3:0]}.
- R6: For cpu_addr_i in $C000-$FFFF (bit 14 = 1), the bank is {outer, 4'hF}, whatever the inner bank holds.
- R7: prg_addr_o is the 19-bit value {bank[4:0], cpu_addr_i[13:0]}.
- R8: After reset all registers are zero, so $8000 maps to ROM address 0x00000 and $C000 maps to 0x3C000.
- R9: A write with cpu_addr_i[15]=1 and slot index 9..12 raises fwd_wr_o in the same cycle, with fwd_idx_o = slot index and fwd_data_o = data. The program mapping is left unchanged. Slots 13..15 raise nothing.
- R10: prg_sel_o is high exactly when cpu_addr_i[15]=1, and wram_sel_o is high exactly when cpu_addr_i[15:13]=3'b011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| prg_addr_o | output | 19 | Mapped program-ROM address |
| prg_sel_o | output | 1 | Address falls in the program window |
| wram_sel_o | output | 1 | Address falls in the work-RAM window |
| fwd_wr_o | output | 1 | Write forwarded to mirroring/interrupt logic |
| fwd_idx_o | output | 4 | Forwarded slot index |
| fwd_data_o | output | 8 | Forwarded data |

## Verification
The bench targets the upper window while slot 0 selects the upper half. A design that pins $C000 to the last bank of the whole ROM would return bank 31 where bank 15 is expected, or the reverse. It writes slot-0 slot numbers below $8000 and expects no change; a decoder that ignores bit 15 would flip the half. It loads slots 1..7 and the high nibble of slot 8 with ones. A design that ORs in other outer registers, or keeps data bits 7:4, would then produce banks outside the expected ones. It also probes the forwarding edges at slots 8, 9, 12 and 13, where an off-by-one range check would raise or drop fwd_wr_o.

// File: rtl/obs_pkg.sv
package obs_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned INNER_W = 4;
  localparam int unsigned WIN_W   = 14;
  localparam int unsigned N_OUTER = 8;
  localparam int unsigned FWD_LO  = 9;
  localparam int unsigned FWD_HI  = 12;
endpackage

// File: rtl/obs_decode.sv
module obs_decode
  import obs_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned NO = N_OUTER,
  parameter int unsigned FL = FWD_LO,
  parameter int unsigned FH = FWD_HI
) (
  input  logic          cpu_wr_i,
  input  logic [AW-1:0] cpu_addr_i,
  output logic [NO-1:0] outer_we_o,
  output logic          inner_we_o,
  output logic          fwd_we_o,
  output logic          prg_sel_o,
  output logic          wram_sel_o
);
  localparam logic [IW-1:0] INNER_IDX = IW'(NO);
  localparam logic [IW-1:0] FWD_LO_IDX = IW'(FL);
  localparam logic [IW-1:0] FWD_HI_IDX = IW'(FH);

  logic [IW-1:0] idx;
  logic          wr_hi;

  assign idx   = cpu_addr_i[IW-1:0];
  assign wr_hi = cpu_wr_i && cpu_addr_i[AW-1];

  for (genvar i = 0; i < NO; i++) begin : g_outer_we
    assign outer_we_o[i] = wr_hi && (idx == IW'(i));
  end

  assign inner_we_o = wr_hi && (idx == INNER_IDX);
  assign fwd_we_o   = wr_hi && (idx >= FWD_LO_IDX) && (idx <= FWD_HI_IDX);
  assign prg_sel_o  = cpu_addr_i[AW-1];
  assign wram_sel_o = (cpu_addr_i[AW-1 -: 3] == 3'b011);
endmodule

// File: rtl/obs_regs.sv
module obs_regs
  import obs_pkg::*;
#(
  parameter int unsigned NO = N_OUTER,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = INNER_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NO-1:0] outer_we_i,
  input  logic          inner_we_i,
  input  logic [DW-1:0] data_i,
  output logic          outer_bit_o,
  output logic [NW-1:0] inner_o
);
  logic [DW-1:0] outer_q [NO];
  logic [NW-1:0] inner_q;

  for (genvar i = 0; i < NO; i++) begin : g_outer
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           outer_q[i] <= '0;
      else if (outer_we_i[i]) outer_q[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         inner_q <= '0;
    else if (inner_we_i) inner_q <= data_i[NW-1:0];
  end

  // held for other board logic; only slot 0 bit 0 steers the ROM here
  logic unused_outer;
  always_comb begin
    unused_outer = ^outer_q[0][DW-1:1];
    for (int i = 1; i < NO; i++) unused_outer ^= ^outer_q[i];
  end

  assign outer_bit_o = outer_q[0][0];
  assign inner_o     = inner_q;
endmodule

// File: rtl/obs_map.sv
module obs_map
  import obs_pkg::*;
#(
  parameter int unsigned NW = INNER_W,
  parameter int unsigned WW = WIN_W
) (
  input  logic            outer_bit_i,
  input  logic [NW-1:0]   inner_i,
  input  logic [WW:0]     win_addr_i,
  output logic [NW+WW:0]  prg_addr_o
);
  logic [NW-1:0] low_bank;

  // upper window pins to last bank of the selected half
  assign low_bank   = win_addr_i[WW] ? {NW{1'b1}} : inner_i;
  assign prg_addr_o = {outer_bit_i, low_bank, win_addr_i[WW-1:0]};
endmodule

// File: rtl/outer_bank_sel.sv
module outer_bank_sel
  import obs_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned NW = INNER_W,
  parameter int unsigned WW = WIN_W,
  parameter int unsigned NO = N_OUTER,
  localparam int unsigned PW = 1 + NW + WW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_wr_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_data_i,
  output logic [PW-1:0] prg_addr_o,
  output logic          prg_sel_o,
  output logic          wram_sel_o,
  output logic          fwd_wr_o,
  output logic [IW-1:0] fwd_idx_o,
  output logic [DW-1:0] fwd_data_o
);
  logic [NO-1:0] outer_we;
  logic          inner_we;
  logic          outer_bit;
  logic [NW-1:0] inner;

  obs_decode #(.AW(AW), .IW(IW), .NO(NO)) u_dec (
    .cpu_wr_i   (cpu_wr_i),
    .cpu_addr_i (cpu_addr_i),
    .outer_we_o (outer_we),
    .inner_we_o (inner_we),
    .fwd_we_o   (fwd_wr_o),
    .prg_sel_o  (prg_sel_o),
    .wram_sel_o (wram_sel_o)
  );

  obs_regs #(.NO(NO), .DW(DW), .NW(NW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .outer_we_i  (outer_we),
    .inner_we_i  (inner_we),
    .data_i      (cpu_data_i),
    .outer_bit_o (outer_bit),
    .inner_o     (inner)
  );

  obs_map #(.NW(NW), .WW(WW)) u_map (
    .outer_bit_i (outer_bit),
    .inner_i     (inner),
    .win_addr_i  (cpu_addr_i[WW:0]),
    .prg_addr_o  (prg_addr_o)
  );

  assign fwd_idx_o  = cpu_addr_i[IW-1:0];
  assign fwd_data_o = cpu_data_i;

  a_r1_low_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !cpu_addr_i[AW-1]) |=> ($stable(outer_bit) && $stable(inner)));

  a_r9_fwd_keeps_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_wr_o |=> ($stable(outer_bit) && $stable(inner)));

  a_r4_inner_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_addr_i[AW-1] && cpu_addr_i[IW-1:0] == IW'(NO))
      |=> (inner == $past(cpu_data_i[NW-1:0])));

  a_r3_outer_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_addr_i[AW-1] && cpu_addr_i[IW-1:0] == '0)
      |=> (outer_bit == $past(cpu_data_i[0])));

  a_r6_hi_window_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prg_sel_o && cpu_addr_i[WW]) |-> (prg_addr_o[PW-2 -: NW] == {NW{1'b1}}
      && prg_addr_o[PW-1] == outer_bit));

  a_r10_sel_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prg_sel_o && wram_sel_o));
endmodule

// File: tb/tb_outer_bank_sel.sv
module tb_outer_bank_sel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [18:0] prg_addr;
  logic        prg_sel, wram_sel, fwd_wr;
  logic [3:0]  fwd_idx;
  logic [7:0]  fwd_data;

  int total = 0;
  int bad = 0;
  logic       m_outer = 1'b0;
  logic [3:0] m_inner = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  outer_bank_sel dut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_wr_i(cpu_wr), .cpu_addr_i(cpu_addr),
    .cpu_data_i(cpu_data), .prg_addr_o(prg_addr), .prg_sel_o(prg_sel),
    .wram_sel_o(wram_sel), .fwd_wr_o(fwd_wr), .fwd_idx_o(fwd_idx),
    .fwd_data_o(fwd_data)
  );

  function automatic logic [18:0] exp_addr(logic [15:0] a, logic o, logic [3:0] n);
    logic [3:0] lo;
    lo = a[14] ? 4'hF : n;
    return {o, lo, a[13:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    logic ef;
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
    #1;
    ef = a[15] && (a[3:0] >= 4'd9) && (a[3:0] <= 4'd12);
    chk("R9 fwd_wr", 32'(fwd_wr), 32'(ef));
    if (ef) begin
      chk("R9 fwd_idx", 32'(fwd_idx), 32'(a[3:0]));
      chk("R9 fwd_data", 32'(fwd_data), 32'(d));
    end
    @(posedge clk);
    if (a[15] && a[3:0] == 4'd0) m_outer = d[0];
    if (a[15] && a[3:0] == 4'd8) m_inner = d[3:0];
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic probe(string req, logic [15:0] a);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = a;
    #1;
    chk("R10 prg_sel", 32'(prg_sel), 32'(a[15]));
    chk("R10 wram_sel", 32'(wram_sel), 32'(a[15:13] == 3'b011));
    if (a[15]) chk(req, 32'(prg_addr), 32'(exp_addr(a, m_outer, m_inner)));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_PERIOD*3);
    @(negedge clk);
    rst_ni = 1'b1;
    // R8 reset state
    probe("R8 reset $8000", 16'h8000);
    chk("R8 reset $8000 abs", 32'(prg_addr), 32'h00000);
    probe("R8 reset $C000", 16'hC000);
    chk("R8 reset $C000 abs", 32'(prg_addr), 32'h3C000);
    // R4 inner load with high nibble ignored, R5 lower window
    do_write(16'h8008, 8'hF5);
    probe("R5 low window", 16'h8123);
    chk("R4 high nibble ignored", 32'(prg_addr), 32'h14123);
    // R3 outer half select, R6 upper window follows the half
    do_write(16'h8000, 8'h01);
    probe("R3 outer low win", 16'hA000);
    chk("R3 outer abs", 32'(prg_addr), 32'h56000);
    probe("R6 hi win upper half", 16'hFFFF);
    chk("R6 hi abs", 32'(prg_addr), 32'h7FFFF);
    // R1 writes below $8000 ignored
    do_write(16'h6000, 8'h00);
    do_write(16'h7FF8, 8'h03);
    probe("R1 low write ignored", 16'h8000);
    chk("R1 abs", 32'(prg_addr), 32'h54000);
    // R2 slots 1..7 and slot0 high bits no effect
    for (int i = 1; i < 8; i++) do_write(16'h8000 | 16'(i), 8'hFF);
    do_write(16'hE000, 8'hFE);
    probe("R2 other outer regs inert", 16'h9ABC);
    chk("R2 abs", 32'(prg_addr), 32'h15ABC);
    // R9 forwarding edges, mapping unchanged
    do_write(16'h8009, 8'h03);
    do_write(16'h800C, 8'hA5);
    do_write(16'h800D, 8'h11);
    do_write(16'h800F, 8'h22);
    do_write(16'h600A, 8'h01);
    probe("R9 map unchanged", 16'hB000);
    probe("R7 hi window", 16'hD555);
    // R10 region flags
    probe("R10 wram", 16'h6001);
    probe("R10 none", 16'h4000);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom % 3 == 0) a = {1'b1, 11'($urandom), 4'($urandom % 9)};
      if ($urandom % 2 == 0) do_write(a, 8'($urandom));
      probe("R7 random map", 16'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule